// File: doc/BRIEF.md
# MESI Coherence Line Controller with Locked Read

This block keeps the coherence state of every line in a small direct-mapped cache and turns each local access and each snooped remote message into a new line state, an outgoing bus message and, where dirty data must leave the cache, a writeback request. Line states use a two-bit code: I=00, S=01, E=10, M=11. The data array and bus arbitration are outside the block. Addresses are line addresses. The low `INDEX_W` bits select the line and the remaining bits form the stored tag.

Besides plain reads and writes, the block accepts a locked read. A locked read forces the line to M with an exclusive-read message and records its address as the single lock of this cache. Until the next accepted local write, any snoop aimed at that address is held off, so the remote requester waits, and a second locked read is stalled. A read-modify-write built from a locked read and a write therefore cannot be interleaved with a remote write.

Every accepted request produces registered results one clock after the edge that accepts it. A snoop that is accepted in a cycle blocks the local port in that same cycle.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset every line is I (00), no lock is held, and `loc_done`, `bus_valid`, `evict_wb`, `snp_done` and `snp_wb` are low.
- R2: A local read (op 00, and the reserved op 11) that hits a valid line with a matching tag sends no bus message and leaves the state unchanged.
- R3: A local read miss sends READ (`bus_msg` 01). It installs E (10) when `loc_sharer` is low and S (01) when it is high. With `EXCL_FILL`=0 it always installs S.
- R4: A local write (op 01) that hits a line in S sends INVALIDATE (11) and moves the line to M.
- R5: A local write that hits a line in E or M moves it to M and sends no bus message.
- R6: A local write miss sends READEX (10) and installs the line in M.
- R7: A locked read (op 10) sends READEX and leaves the line in M whatever its earlier state, and it sets `lock_held`.
- R8: A snooped READ (01) that matches a valid line moves S, E or M to S and raises `snp_wb` only for M. A snoop that matches no valid line changes nothing and raises no writeback.
- R9: A snooped READEX (10) or INVALIDATE (11) that matches a valid line moves it to I and raises `snp_wb` only when the line was M.
- R10: While a lock is held, `snp_ready` is low for a snoop whose address equals the locked address. Snoops to any other address are still serviced.
- R11: The next accepted local write, to any address, clears the lock.
- R12: A locked read presented while a lock is held sees `loc_ready` low and is not accepted.
- R13: A local miss that replaces a line held in M under a different tag raises `evict_wb` together with the victim's line address.
- R14: In a cycle where a snoop is accepted, `loc_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | 00 read, 01 write, 10 locked read, 11 treated as read |
| loc_addr | input | ADDR_W | Local line address |
| loc_sharer | input | 1 | Another cache holds the line (chooses S over E on a read fill) |
| loc_ready | output | 1 | Local request accepted this cycle if valid |
| loc_done | output | 1 | Pulse one cycle after a local request is accepted |
| loc_state | output | 2 | Line state after the accepted local request |
| bus_valid | output | 1 | A bus message is issued |
| bus_msg | output | 2 | 01 READ, 10 READEX, 11 INVALIDATE |
| bus_addr | output | ADDR_W | Address of the bus message |
| evict_wb | output | 1 | Victim line in M must be written back |
| evict_addr | output | ADDR_W | Victim line address |
| snp_valid | input | 1 | Remote message present |
| snp_msg | input | 2 | 01 READ, 10 READEX, 11 INVALIDATE, 00 no action |
| snp_addr | input | ADDR_W | Remote message line address |
| snp_ready | output | 1 | Remote message accepted this cycle if valid |
| snp_done | output | 1 | Pulse one cycle after a snoop is accepted |
| snp_wb | output | 1 | Snooped line was M and must be written back |
| lock_held | output | 1 | A locked read is outstanding |

## Verification
The bench builds the block with `ADDR_W`=8, `INDEX_W`=2 and `EXCL_FILL`=1. With only four lines and a handful of tags, aliasing at the same index is frequent, so evictions of dirty victims and snoops that miss on a reused index are common. Directed sequences place a lock under contention from a held snoop and from a second locked read. A random phase over a small address set then mixes locked reads, writes and all three snoop kinds, so lock release and deferred snoops meet every line state.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;

   typedef enum logic [1:0] {
      LN_I = 2'b00,
      LN_S = 2'b01,
      LN_E = 2'b10,
      LN_M = 2'b11
   } line_st_t;

   typedef enum logic [1:0] {
      OP_RD   = 2'b00,
      OP_WR   = 2'b01,
      OP_RDLK = 2'b10,
      OP_RSV  = 2'b11
   } loc_op_t;

   typedef enum logic [1:0] {
      MSG_NONE   = 2'b00,
      MSG_READ   = 2'b01,
      MSG_READEX = 2'b10,
      MSG_INVAL  = 2'b11
   } bus_msg_t;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
   import mesi_line_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   input  logic [IDX_W-1:0] b_idx,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  line_st_t         w_st,
   input  logic [TAG_W-1:0] w_tag,
   output line_st_t         a_st,
   output logic [TAG_W-1:0] a_tag,
   output line_st_t         b_st,
   output logic [TAG_W-1:0] b_tag
);
   localparam int NLINES = 1 << IDX_W;

   line_st_t         st_r  [NLINES];
   logic [TAG_W-1:0] tag_r [NLINES];

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r[g]  <= LN_I;
            tag_r[g] <= '0;
         end else if (we && (w_idx == IDX_W'(g))) begin
            st_r[g]  <= w_st;
            tag_r[g] <= w_tag;
         end
      end
   end

   assign a_st  = st_r[a_idx];
   assign a_tag = tag_r[a_idx];
   assign b_st  = st_r[b_idx];
   assign b_tag = tag_r[b_idx];
endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
   import mesi_line_pkg::*;
#(
   parameter bit EXCL_FILL = 1'b1
) (
   input  loc_op_t  op,
   input  logic     hit,
   input  line_st_t cur,
   input  logic     sharer,
   output line_st_t nxt,
   output bus_msg_t msg
);
   line_st_t fill_st;

   if (EXCL_FILL) begin : g_excl
      assign fill_st = sharer ? LN_S : LN_E;
   end else begin : g_shared
      logic unused_sharer;
      assign unused_sharer = sharer;
      assign fill_st = LN_S;
   end

   always_comb begin
      nxt = cur;
      msg = MSG_NONE;
      case (op)
         OP_WR: begin
            nxt = LN_M;
            if (!hit)            msg = MSG_READEX;
            else if (cur == LN_S) msg = MSG_INVAL;
            else                 msg = MSG_NONE;
         end
         OP_RDLK: begin
            nxt = LN_M;
            msg = MSG_READEX;
         end
         default: begin
            if (hit) begin
               nxt = cur;
               msg = MSG_NONE;
            end else begin
               nxt = fill_st;
               msg = MSG_READ;
            end
         end
      endcase
   end
endmodule

// File: rtl/mesi_snoop_fsm.sv
module mesi_snoop_fsm
   import mesi_line_pkg::*;
(
   input  bus_msg_t msg,
   input  logic     hit,
   input  line_st_t cur,
   output logic     upd,
   output line_st_t nxt,
   output logic     wb
);
   always_comb begin
      upd = hit && (msg != MSG_NONE);
      wb  = upd && (cur == LN_M);
      case (msg)
         MSG_READ: nxt = LN_S;
         MSG_READEX,
         MSG_INVAL: nxt = LN_I;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/mesi_lock_ctl.sv
module mesi_lock_ctl #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              clr,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              held,
   output logic [ADDR_W-1:0] lock_addr,
   output logic              probe_block
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= 1'b0;
         lock_addr <= '0;
      end else if (clr) begin
         held <= 1'b0;
      end else if (set) begin
         held      <= 1'b1;
         lock_addr <= set_addr;
      end
   end

   assign probe_block = held && (probe_addr == lock_addr);
endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
   import mesi_line_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int INDEX_W   = 2,
   parameter bit EXCL_FILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_valid,
   input  logic [1:0]        loc_op,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic              loc_sharer,
   output logic              loc_ready,
   output logic              loc_done,
   output logic [1:0]        loc_state,
   output logic              bus_valid,
   output logic [1:0]        bus_msg,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              evict_wb,
   output logic [ADDR_W-1:0] evict_addr,
   input  logic              snp_valid,
   input  logic [1:0]        snp_msg,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_ready,
   output logic              snp_done,
   output logic              snp_wb,
   output logic              lock_held
);
   localparam int TAG_W = ADDR_W - INDEX_W;

   if (INDEX_W < 1 || INDEX_W >= ADDR_W) begin : g_bad_index
      $error("mesi_line_ctl: INDEX_W must lie in 1..ADDR_W-1");
   end
   if (INDEX_W > 10) begin : g_bad_depth
      $error("mesi_line_ctl: INDEX_W too large for a register array");
   end

   loc_op_t  lop;
   bus_msg_t smsg;
   assign lop  = loc_op_t'(loc_op);
   assign smsg = bus_msg_t'(snp_msg);

   logic [INDEX_W-1:0] loc_idx, snp_idx;
   logic [TAG_W-1:0]   loc_tag, snp_tag;
   assign loc_idx = loc_addr[INDEX_W-1:0];
   assign loc_tag = loc_addr[ADDR_W-1:INDEX_W];
   assign snp_idx = snp_addr[INDEX_W-1:0];
   assign snp_tag = snp_addr[ADDR_W-1:INDEX_W];

   // array
   line_st_t         loc_cur, snp_cur, w_st;
   logic [TAG_W-1:0] loc_old_tag, snp_old_tag, w_tag;
   logic [INDEX_W-1:0] w_idx;
   logic             arr_we;

   mesi_state_array #(.IDX_W(INDEX_W), .TAG_W(TAG_W)) i_array (
      .clk   (clk),
      .rst_n (rst_n),
      .a_idx (loc_idx),
      .b_idx (snp_idx),
      .we    (arr_we),
      .w_idx (w_idx),
      .w_st  (w_st),
      .w_tag (w_tag),
      .a_st  (loc_cur),
      .a_tag (loc_old_tag),
      .b_st  (snp_cur),
      .b_tag (snp_old_tag)
   );

   logic loc_hit, snp_hit;
   assign loc_hit = (loc_cur != LN_I) && (loc_old_tag == loc_tag);
   assign snp_hit = (snp_cur != LN_I) && (snp_old_tag == snp_tag);

   // lock
   logic              lk_held, lk_block;
   logic [ADDR_W-1:0] lock_addr_q;
   logic              loc_fire, snp_fire;

   mesi_lock_ctl #(.ADDR_W(ADDR_W)) i_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .set         (loc_fire && (lop == OP_RDLK)),
      .clr         (loc_fire && (lop == OP_WR)),
      .set_addr    (loc_addr),
      .probe_addr  (snp_addr),
      .held        (lk_held),
      .lock_addr   (lock_addr_q),
      .probe_block (lk_block)
   );

   assign snp_ready = !lk_block;
   assign snp_fire  = snp_valid && snp_ready;
   assign loc_ready = !snp_fire && !((lop == OP_RDLK) && lk_held);
   assign loc_fire  = loc_valid && loc_ready;

   // transition logic
   line_st_t loc_nxt, snp_nxt;
   bus_msg_t loc_msg;
   logic     snp_upd, snp_wb_c;

   mesi_local_fsm #(.EXCL_FILL(EXCL_FILL)) i_local (
      .op     (lop),
      .hit    (loc_hit),
      .cur    (loc_cur),
      .sharer (loc_sharer),
      .nxt    (loc_nxt),
      .msg    (loc_msg)
   );

   mesi_snoop_fsm i_snoop (
      .msg (smsg),
      .hit (snp_hit),
      .cur (snp_cur),
      .upd (snp_upd),
      .nxt (snp_nxt),
      .wb  (snp_wb_c)
   );

   // single write port: a fired snoop excludes a local access
   always_comb begin
      if (snp_fire) begin
         arr_we = snp_upd;
         w_idx  = snp_idx;
         w_st   = snp_nxt;
         w_tag  = snp_old_tag;
      end else begin
         arr_we = loc_fire;
         w_idx  = loc_idx;
         w_st   = loc_nxt;
         w_tag  = loc_tag;
      end
   end

   logic evict_c;
   assign evict_c = loc_fire && !loc_hit && (loc_cur == LN_M);

   // registered results
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_done   <= 1'b0;
         loc_state  <= LN_I;
         bus_valid  <= 1'b0;
         bus_msg    <= MSG_NONE;
         bus_addr   <= '0;
         evict_wb   <= 1'b0;
         evict_addr <= '0;
         snp_done   <= 1'b0;
         snp_wb     <= 1'b0;
      end else begin
         loc_done  <= loc_fire;
         bus_valid <= loc_fire && (loc_msg != MSG_NONE);
         bus_msg   <= loc_fire ? loc_msg : MSG_NONE;
         evict_wb  <= evict_c;
         snp_done  <= snp_fire;
         snp_wb    <= snp_fire && snp_wb_c;
         if (loc_fire) begin
            loc_state <= loc_nxt;
            bus_addr  <= loc_addr;
         end
         if (evict_c) evict_addr <= {loc_old_tag, loc_idx};
      end
   end

   assign lock_held = lk_held;
endmodule

// File: rtl/mesi_line_ctl_chk.sv
module mesi_line_ctl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              loc_valid,
   input logic [1:0]        loc_op,
   input logic              loc_ready,
   input logic [1:0]        loc_state,
   input logic              bus_valid,
   input logic [1:0]        bus_msg,
   input logic              snp_valid,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              snp_ready,
   input logic              lock_held,
   input logic [ADDR_W-1:0] lock_addr_q,
   input logic              loc_hit,
   input logic [1:0]        loc_cur
);
   logic lfire;
   assign lfire = loc_valid && loc_ready;

   assert_lock_to_m_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lfire && loc_op == 2'b10 |=> lock_held && loc_state == 2'b11 && bus_valid && bus_msg == 2'b10);

   assert_snoop_deferred_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_held && snp_valid && snp_addr == lock_addr_q |-> !snp_ready);

   assert_single_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lock_held && loc_op == 2'b10 |-> !loc_ready);

   assert_snoop_first_R14: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_ready |-> !loc_ready);

   assert_silent_upgrade_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lfire && loc_op == 2'b01 && loc_hit && loc_cur != 2'b01 |=> !bus_valid && loc_state == 2'b11);

   assert_write_unlocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lfire && loc_op == 2'b01 |=> !lock_held);
endmodule

bind mesi_line_ctl mesi_line_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .loc_valid   (loc_valid),
   .loc_op      (loc_op),
   .loc_ready   (loc_ready),
   .loc_state   (loc_state),
   .bus_valid   (bus_valid),
   .bus_msg     (bus_msg),
   .snp_valid   (snp_valid),
   .snp_addr    (snp_addr),
   .snp_ready   (snp_ready),
   .lock_held   (lock_held),
   .lock_addr_q (lock_addr_q),
   .loc_hit     (loc_hit),
   .loc_cur     (loc_cur)
);

// File: tb/test_mesi_line_ctl.sv
module test_mesi_line_ctl;
   localparam int AW = 8;
   localparam int IW = 2;
   localparam int NL = 1 << IW;

   logic clk = 0, rst_n = 0;
   logic loc_valid = 0, loc_sharer = 0, snp_valid = 0;
   logic [1:0] loc_op = 0, snp_msg = 0;
   logic [AW-1:0] loc_addr = 0, snp_addr = 0;
   logic loc_ready, loc_done, bus_valid, evict_wb, snp_ready, snp_done, snp_wb, lock_held;
   logic [1:0] loc_state, bus_msg;
   logic [AW-1:0] bus_addr, evict_addr;

   always #5 clk = ~clk;

   mesi_line_ctl #(.ADDR_W(AW), .INDEX_W(IW), .EXCL_FILL(1'b1)) i_mesi_line_ctl (
      .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_op(loc_op), .loc_addr(loc_addr),
      .loc_sharer(loc_sharer), .loc_ready(loc_ready), .loc_done(loc_done), .loc_state(loc_state),
      .bus_valid(bus_valid), .bus_msg(bus_msg), .bus_addr(bus_addr), .evict_wb(evict_wb),
      .evict_addr(evict_addr), .snp_valid(snp_valid), .snp_msg(snp_msg), .snp_addr(snp_addr),
      .snp_ready(snp_ready), .snp_done(snp_done), .snp_wb(snp_wb), .lock_held(lock_held));

   int total = 0, bad = 0;
   bit finished = 0;
   int m_st [NL];
   int m_tg [NL];
   bit m_lock = 0;
   int m_lock_addr = 0;

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: drive, check ready flags, advance model, check registered results
   task automatic step(bit lv, int op, int a, bit sh, bit sv, int sm, int sa);
      bit es, el, sf, lf, lhit, ev, swb, ebv;
      int li, lt, si, st, eva, est, emsg;
      string ltag, stag;
      loc_valid = lv; loc_op = op[1:0]; loc_addr = a[AW-1:0]; loc_sharer = sh;
      snp_valid = sv; snp_msg = sm[1:0]; snp_addr = sa[AW-1:0];
      #1;
      es = !(m_lock && sa == m_lock_addr);
      el = !(sv && es) && !(op == 2 && m_lock);
      chk(op == 2 ? "R12" : "R14", loc_ready, el);
      chk("R10", snp_ready, es);
      sf = sv && es;
      lf = lv && el;
      swb = 0; ev = 0; ebv = 0; eva = 0; est = 0; emsg = 0;
      stag = (sm == 1) ? "R8" : "R9";
      ltag = "R2";
      if (sf) begin
         si = sa % NL; st = sa / NL;
         if (sm != 0 && m_st[si] != 0 && m_tg[si] == st) begin
            swb = (m_st[si] == 3);
            m_st[si] = (sm == 1) ? 1 : 0;
         end
      end else if (lf) begin
         li = a % NL; lt = a / NL;
         lhit = (m_st[li] != 0) && (m_tg[li] == lt);
         if (!lhit && m_st[li] == 3) begin ev = 1; eva = m_tg[li] * NL + li; end
         if (op == 1) begin
            if (!lhit) begin emsg = 2; ltag = "R6"; end
            else if (m_st[li] == 1) begin emsg = 3; ltag = "R4"; end
            else ltag = "R5";
            est = 3; m_lock = 0;
         end else if (op == 2) begin
            emsg = 2; est = 3; ltag = "R7"; m_lock = 1; m_lock_addr = a;
         end else begin
            if (lhit) begin est = m_st[li]; ltag = "R2"; end
            else begin emsg = 1; est = sh ? 1 : 2; ltag = "R3"; end
         end
         ebv = (emsg != 0);
         m_st[li] = est; m_tg[li] = lt;
      end
      @(posedge clk); #1;
      chk(ltag, loc_done, lf);
      if (lf) begin
         chk(ltag, loc_state, est);
         chk(ltag, bus_valid, ebv);
         if (ebv) begin chk(ltag, bus_msg, emsg); chk(ltag, bus_addr, a); end
      end else chk("R14", bus_valid, 0);
      chk("R13", evict_wb, ev);
      if (ev) chk("R13", evict_addr, eva);
      chk(stag, snp_done, sf);
      chk(stag, snp_wb, swb);
      chk(m_lock ? "R7" : "R11", lock_held, m_lock);
      @(negedge clk);
   endtask

   task automatic loc(int op, int a, bit sh = 0);
      step(1, op, a, sh, 0, 0, 0);
   endtask

   task automatic snp(int sm, int sa);
      step(0, 0, 0, 0, 1, sm, sa);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tg[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", lock_held, 0); chk("R1", loc_done, 0); chk("R1", bus_valid, 0);
      chk("R1", evict_wb, 0); chk("R1", snp_done, 0); chk("R1", snp_wb, 0);
      rst_n = 1;
      @(negedge clk);
      loc(0, 'h10, 0);          // R3 miss on empty array -> E, READ
      loc(0, 'h10, 0);          // R2 read hit
      loc(3, 'h10, 0);          // R2 reserved op behaves as read
      loc(1, 'h10);             // R5 E -> M silent
      loc(0, 'h21, 1);          // R3 sharer -> S
      loc(1, 'h21);             // R4 S -> M INVAL
      loc(1, 'h32);             // R6 write miss READEX
      snp(1, 'h32);             // R8 M -> S with wb
      snp(1, 'h32);             // R8 S stays S, no wb
      snp(2, 'h21);             // R9 M -> I with wb
      snp(3, 'h32);             // R9 S -> I no wb
      snp(1, 'h55);             // R8 miss: no change
      snp(2, 'h13);             // R9 index 3 empty: no change
      loc(0, 'h21, 0);          // R3 refill E
      loc(1, 'h14);             // R13 evict M victim 0x10
      loc(2, 'h21);             // R7 lock E line
      for (int k = 0; k < 3; k++)
         step(1, 2, 'h32, 0, 1, 1, 'h21);   // R10 snoop deferred, R12 lock stalled
      step(1, 0, 'h21, 0, 1, 1, 'h14);      // R14 other snoop wins, R10 not blocked
      step(1, 1, 'h21, 0, 1, 1, 'h21);      // R11 write releases while snoop waits
      snp(1, 'h21);                          // R10 snoop now serviced, M -> S wb
      loc(2, 'h33);                          // R7 lock from I
      loc(1, 'h40);                          // R11 release by write elsewhere
      loc(2, 'h40);                          // R7 lock on M line
      snp(2, 'h40);                          // R10 blocked
      loc(1, 'h40);                          // R11
      // random mix
      for (int n = 0; n < 600; n++) begin
         int a, sa, op, sm;
         a  = ($urandom % 3) * NL + ($urandom % NL);
         sa = ($urandom % 3) * NL + ($urandom % NL);
         op = $urandom % 4;
         sm = $urandom % 4;
         step($urandom % 4 != 0, op, a, $urandom % 2, $urandom % 3 == 0, sm, sa);
      end
      step(0, 0, 0, 0, 0, 0, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule